// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an idle-high asynchronous serial line. It counts sample ticks at 1, 16 or 64 per bit and confirms a falling start edge halfway through the bit. Each later bit is sampled at its centre. Five to eight data bits are assembled least significant bit first. An optional parity bit is checked against an even or odd rule, and the first stop bit is checked. Character length, parity and clock factor are run-time inputs. Software is expected to change them only while no character is in flight.

A finished character goes into a single holding register. It is offered on a valid/ready output: `rx_valid` is high while a character is held, and a cycle with both `rx_valid` and `rx_ready` high consumes it. The serial side has no back-pressure. A character that completes while the previous one is still held replaces it and raises the overrun flag, so holding `rx_ready` low never stalls the line. Parity, overrun and framing errors each have a sticky flag, cleared only by a pulse on `err_clear`.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_data` and the three error flags are all zero.
- R2: `cfg_len` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, received least significant bit first. Unused high bits of `rx_data` read as zero.
- R3: `cfg_factor` selects 1 (01), 16 (10) or 64 (11) sample ticks per bit. Code 00 behaves as 1.
- R4: At 16 and 64 ticks per bit, a low level that has gone high again by the middle of the start bit is discarded, and no character results.
- R5: With `cfg_par_en` high, one parity bit follows the data. When `cfg_par_even` is 1, the data plus parity must hold an even number of ones; when it is 0, an odd number. A mismatch sets `par_err`, and the character is still delivered.
- R6: A low first stop bit sets `frm_err` and the character is still delivered. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: A delivered character sets `rx_valid`. A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` on the next edge.
- R8: A character that completes while `rx_valid` is set, and is not consumed in that cycle, sets `ovr_err` and replaces `rx_data`.
- R9: Each error flag stays set until a cycle with `err_clear` high. If a new error occurs in that same cycle, the flag stays set.
- R10: While `rx_enable` is low, no start bit is detected, and any character in progress is abandoned.
- R11: Bit timing advances only in cycles where `samp_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | Sample-rate enable, one pulse per sample period |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Receive enable |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_factor | input | 2 | Sample ticks per bit code |
| err_clear | input | 1 | Clears all three error flags |
| rx_data | output | 8 | Held character, zero-extended |
| rx_valid | output | 1 | Character held (receiver ready) |
| rx_ready | input | 1 | Consumer takes the held character |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |

## Verification
Characters are sent across every length code, with parity off, even and odd, and at all three clock factors plus the 00 code. Values such as A5 at five bits and FF at six bits show whether high bits are masked and whether the bit order is right. A deliberately flipped parity bit separates parity checking from framing, and a low stop bit does the reverse. Two unread characters in a row expose overrun and replacement. Short low glitches, a disabled receiver and a halved tick rate each show whether the start qualification, the enable gating and the tick gating are honoured.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_START   = 3'd1,
    ST_DATA    = 3'd2,
    ST_PARITY  = 3'd3,
    ST_STOP    = 3'd4,
    ST_WAIT_HI = 3'd5
  } rx_state_e;

  localparam logic [1:0] FAC_X1  = 2'b01;
  localparam logic [1:0] FAC_X16 = 2'b10;
  localparam logic [1:0] FAC_X64 = 2'b11;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= 1'b1;
        else        sr_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign line_o = sr_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MID_FACTOR = 16,
  parameter int unsigned MAX_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              enable_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [1:0]        factor_i,
  output logic              chr_valid_o,
  output logic [DATA_W-1:0] chr_data_o,
  output logic              chr_par_o,
  output logic              chr_frm_o
);

  localparam int unsigned CNT_W    = $clog2(MAX_FACTOR);
  localparam int unsigned BIT_W    = $clog2(DATA_W + 1);
  localparam int unsigned MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] MID_PER_M1  = CNT_W'(MID_FACTOR - 1);
  localparam logic [CNT_W-1:0] MAX_PER_M1  = CNT_W'(MAX_FACTOR - 1);
  localparam logic [CNT_W-1:0] MID_HALF_M1 = CNT_W'(MID_FACTOR / 2 - 1);
  localparam logic [CNT_W-1:0] MAX_HALF_M1 = CNT_W'(MAX_FACTOR / 2 - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_acc_q;
  logic              par_bad_q;

  logic [CNT_W-1:0]  period_m1;
  logic [CNT_W-1:0]  half_m1;
  logic              single_rate;
  logic [BIT_W-1:0]  nbits;
  logic [DATA_W-1:0] aligned;
  logic              sample;

  always_comb begin
    case (factor_i)
      FAC_X16: begin period_m1 = MID_PER_M1; half_m1 = MID_HALF_M1; single_rate = 1'b0; end
      FAC_X64: begin period_m1 = MAX_PER_M1; half_m1 = MAX_HALF_M1; single_rate = 1'b0; end
      default: begin period_m1 = '0;         half_m1 = '0;          single_rate = 1'b1; end
    endcase
  end

  assign nbits   = BIT_W'(MIN_BITS) + BIT_W'(len_i);
  assign aligned = shreg_q >> (BIT_W'(DATA_W) - nbits);
  assign sample  = tick_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bit_idx_q   <= '0;
      shreg_q     <= '0;
      par_acc_q   <= 1'b0;
      par_bad_q   <= 1'b0;
      chr_valid_o <= 1'b0;
      chr_data_o  <= '0;
      chr_par_o   <= 1'b0;
      chr_frm_o   <= 1'b0;
    end else begin
      chr_valid_o <= 1'b0;
      if (!enable_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (tick_i && !line_i) begin
              shreg_q   <= '0;
              bit_idx_q <= '0;
              par_acc_q <= 1'b0;
              par_bad_q <= 1'b0;
              if (single_rate) begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
              end else begin
                state_q <= ST_START;
                cnt_q   <= half_m1;
              end
            end
          end
          ST_START: begin
            if (tick_i) begin
              if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
              end else if (!line_i) begin
                state_q <= ST_DATA;
                cnt_q   <= period_m1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_DATA: begin
            if (tick_i && cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (sample) begin
              shreg_q   <= {line_i, shreg_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ line_i;
              bit_idx_q <= bit_idx_q + 1'b1;
              cnt_q     <= period_m1;
              if (bit_idx_q == nbits - 1'b1)
                state_q <= par_en_i ? ST_PARITY : ST_STOP;
            end
          end
          ST_PARITY: begin
            if (tick_i && cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (sample) begin
              par_bad_q <= par_even_i ? (par_acc_q ^ line_i) : ~(par_acc_q ^ line_i);
              cnt_q     <= period_m1;
              state_q   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tick_i && cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (sample) begin
              chr_valid_o <= 1'b1;
              chr_data_o  <= aligned;
              chr_par_o   <= par_bad_q;
              chr_frm_o   <= ~line_i;
              state_q     <= line_i ? ST_IDLE : ST_WAIT_HI;
            end
          end
          ST_WAIT_HI: begin
            if (line_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> state_q == ST_IDLE);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid_o |-> ((chr_data_o >> nbits) == '0));

  // R6
  break_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid_o && chr_frm_o && !$past(!enable_i)) |-> state_q == ST_WAIT_HI);

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && enable_i && state_q inside {ST_START, ST_DATA, ST_PARITY, ST_STOP})
      |=> $stable(cnt_q));

endmodule

// File: rtl/rx_hold_flags.sv
module rx_hold_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid_i,
  input  logic [DATA_W-1:0] chr_data_i,
  input  logic              chr_par_i,
  input  logic              chr_frm_i,
  input  logic              rd_ready_i,
  input  logic              err_clear_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_o,
  output logic              ovr_o,
  output logic              frm_o
);

  logic consume;
  assign consume = valid_o && rd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      par_o   <= 1'b0;
      ovr_o   <= 1'b0;
      frm_o   <= 1'b0;
    end else begin
      if (chr_valid_i) begin
        data_o  <= chr_data_i;
        valid_o <= 1'b1;
      end else if (consume) begin
        valid_o <= 1'b0;
      end

      if (chr_valid_i && valid_o && !consume) ovr_o <= 1'b1;
      else if (err_clear_i)                   ovr_o <= 1'b0;

      if (chr_valid_i && chr_par_i) par_o <= 1'b1;
      else if (err_clear_i)         par_o <= 1'b0;

      if (chr_valid_i && chr_frm_i) frm_o <= 1'b1;
      else if (err_clear_i)         frm_o <= 1'b0;
    end
  end

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && rd_ready_i && !chr_valid_i) |=> !valid_o);

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(valid_o));

  // R9
  sticky_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_o && !err_clear_i) |=> par_o);

  // R9
  sticky_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_o && !err_clear_i) |=> frm_o);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MID_FACTOR  = 16,
  parameter int unsigned MAX_FACTOR  = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_factor,
  input  logic              err_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err
);

  logic              line_s;
  logic              chr_valid;
  logic [DATA_W-1:0] chr_data;
  logic              chr_par;
  logic              chr_frm;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (rx_line),
    .line_o (line_s)
  );

  rx_frame_fsm #(
    .DATA_W     (DATA_W),
    .MID_FACTOR (MID_FACTOR),
    .MAX_FACTOR (MAX_FACTOR)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (samp_tick),
    .line_i      (line_s),
    .enable_i    (rx_enable),
    .len_i       (cfg_len),
    .par_en_i    (cfg_par_en),
    .par_even_i  (cfg_par_even),
    .factor_i    (cfg_factor),
    .chr_valid_o (chr_valid),
    .chr_data_o  (chr_data),
    .chr_par_o   (chr_par),
    .chr_frm_o   (chr_frm)
  );

  rx_hold_flags #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .chr_valid_i (chr_valid),
    .chr_data_i  (chr_data),
    .chr_par_i   (chr_par),
    .chr_frm_i   (chr_frm),
    .rd_ready_i  (rx_ready),
    .err_clear_i (err_clear),
    .data_o      (rx_data),
    .valid_o     (rx_valid),
    .par_o       (par_err),
    .ovr_o       (ovr_err),
    .frm_o       (frm_err)
  );

endmodule

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] lc;
    logic       pen;
    logic       ev;
    logic [1:0] fc;
    logic       flip;
    logic       bad;
    logic [7:0] xd;
    logic       xp;
    logic       xf;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h4E, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 8'h4E, 1'b0, 1'b0},
    '{8'hA5, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0},
    '{8'hFF, 2'b01, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b0},
    '{8'h3C, 2'b10, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{8'h55, 2'b11, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0},
    '{8'h81, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    '{8'h2A, 2'b10, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},
    '{8'h00, 2'b00, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{8'hC3, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b1;
  logic       rx_line = 1'b1;
  logic       rx_enable = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic [1:0] cfg_factor = 2'b10;
  logic       err_clear = 1'b0;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, ovr_err, frm_err;

  int checks = 0;
  int failures = 0;
  int tick_div = 1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div == 1) samp_tick <= 1'b1;
    else               samp_tick <= ~samp_tick;
  end

  serial_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_factor(cfg_factor), .err_clear(err_clear),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b, input int per);
    rx_line = b;
    repeat (per) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] lc, input logic pen,
                            input logic ev, input logic [1:0] fc, input logic flip,
                            input logic bad);
    int f;
    int per;
    int nb;
    logic [7:0] m;
    logic p;
    f   = (fc == 2'b10) ? 16 : (fc == 2'b11) ? 64 : 1;
    per = f * tick_div;
    nb  = 5 + int'(lc);
    m   = d & (8'hFF >> (3 - int'(lc)));
    p   = (ev ? ^m : ~^m) ^ flip;
    cfg_len = lc; cfg_par_en = pen; cfg_par_even = ev; cfg_factor = fc;
    @(negedge clk);
    hold_bit(1'b0, per);
    for (int i = 0; i < nb; i++) hold_bit(d[i], per);
    if (pen) hold_bit(p, per);
    hold_bit(~bad, per);
    rx_line = 1'b1;
    repeat (4 * tick_div + 4) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rx_valid", {7'b0, rx_valid}, 8'h00);
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 par_err", {7'b0, par_err}, 8'h00);
    chk("R1 ovr_err", {7'b0, ovr_err}, 8'h00);
    chk("R1 frm_err", {7'b0, frm_err}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R5 R6 R7: vector walk
    for (int v = 0; v < NVEC; v++) begin
      pulse_clear();
      send_frame(VECS[v].d, VECS[v].lc, VECS[v].pen, VECS[v].ev, VECS[v].fc,
                 VECS[v].flip, VECS[v].bad);
      chk("R7 valid after frame", {7'b0, rx_valid}, 8'h01);
      chk("R2 R3 data", rx_data, VECS[v].xd);
      chk("R5 parity flag", {7'b0, par_err}, {7'b0, VECS[v].xp});
      chk("R6 framing flag", {7'b0, frm_err}, {7'b0, VECS[v].xf});
      chk("R8 no overrun", {7'b0, ovr_err}, 8'h00);
      pulse_read();
      chk("R7 valid cleared by read", {7'b0, rx_valid}, 8'h00);
    end

    // R8 overrun and replacement
    pulse_clear();
    send_frame(8'h11, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    send_frame(8'h22, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R8 overrun set", {7'b0, ovr_err}, 8'h01);
    chk("R8 data replaced", rx_data, 8'h22);
    chk("R8 still valid", {7'b0, rx_valid}, 8'h01);
    // R9 clear
    pulse_clear();
    chk("R9 overrun cleared", {7'b0, ovr_err}, 8'h00);
    pulse_read();

    // R9 sticky parity flag across a good character
    send_frame(8'h0F, 2'b11, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0);
    pulse_read();
    send_frame(8'h70, 2'b11, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R9 parity sticky", {7'b0, par_err}, 8'h01);
    chk("R9 good data", rx_data, 8'h70);
    pulse_clear();
    chk("R9 parity cleared", {7'b0, par_err}, 8'h00);
    pulse_read();

    // R10 receiver disabled
    rx_enable = 1'b0;
    send_frame(8'h99, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R10 no char while disabled", {7'b0, rx_valid}, 8'h00);
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);

    // R4 glitch shorter than half a bit at 16x
    cfg_factor = 2'b10;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 glitch rejected", {7'b0, rx_valid}, 8'h00);
    send_frame(8'h5A, 2'b11, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R4 next char ok", rx_data, 8'h5A);
    chk("R4 no overrun", {7'b0, ovr_err}, 8'h00);
    pulse_read();

    // R11 tick every other cycle
    tick_div = 2;
    repeat (4) @(negedge clk);
    send_frame(8'h96, 2'b11, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R11 valid at half tick rate", {7'b0, rx_valid}, 8'h01);
    chk("R11 data at half tick rate", rx_data, 8'h96);
    chk("R11 no parity error", {7'b0, par_err}, 8'h00);
    pulse_read();
    tick_div = 1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule